// File: doc/BRIEF.md
# Two-Cycle Memory-to-Memory DMA Channel

This block is a single DMA channel that moves data as a sequence of units, each unit being one read bus cycle at a source address followed by one write bus cycle at a destination address. Software sets it up through a small register port: a source address, a destination address, a byte count, a control word and a status word. Each side has its own access size (byte, 16-bit word or 32-bit long) and its own choice of a fixed address, for a device data port, or an address that steps forward, for a memory buffer. Because every unit passes through an internal holding register, a narrow device always sees its data on the byte lanes that match its own address and size.

The channel runs either continuously, starting the next unit as soon as the previous one ends, or in request-paced mode, where one external request pulse moves exactly one unit. It stops on completion (count reaches zero), on a bus error response, or when software clears the run bit. Completion sets a done flag and, when enabled, drives an interrupt line.

Top module: `dma_chan`

## Requirements
- R1: After reset the status word reads 0, the count reads 0, bus_req is low and irq is low.
- R2: Each unit is a read cycle (bus_we=0) at the source address, held until bus_ack, followed by a write cycle (bus_we=1) at the destination address, held until bus_ack; no other bus cycles occur.
- R3: Size codes are 00 = long (4 bytes), 01 = byte, 10 = word (2 bytes); code 11 is reserved. Setting the run bit with a reserved code on either side, or with a count that is not a multiple of the larger of the two sizes, starts no bus cycle and sets status bit 2 (configuration error).
- R4: After each completed unit, a side whose fixed bit is 0 advances its address by its own size in bytes; a side whose fixed bit is 1 keeps its address.
- R5: The count register keeps only its low 24 bits (writing 0xAB000010 reads back 0x10); it falls by the source size after each completed unit and reads 0 after completion.
- R6: Data lanes are big-endian: the byte at address offset k sits on bus bits [31-8k:24-8k] with bus_be bit 3-k; a word at offset 0 uses bus_be 1100, at offset 2 uses 0011; a long uses 1111. The unit value is the source data right-justified; the write carries its low destination-size bytes (zero-extended when the destination is wider).
- R7: With control bit 1 (request-paced) set, no bus cycle starts until an xreq pulse; each accepted pulse moves exactly one unit, and pulses arriving while a unit is on the bus are ignored.
- R8: When the last unit completes, status bit 0 (done) is set and the channel goes idle; irq is high exactly when done is set and control bit 2 (interrupt enable) is set.
- R9: Writing the control word with bit 0 (run) = 0 ends any transfer: bus_req is low from the next cycle, no further bus cycle starts and done is not set.
- R10: A bus_err response on either cycle stops the channel, sets status bit 1, leaves done clear and leaves the count unchanged for the failed unit.
- R11: Writing the status word with bit 0 = 1 clears done, the bus-error bit and the configuration-error bit; if the last unit completes in the same cycle, done stays set.
- R12: Setting the run bit with a count of 0 sets done at once without any bus cycle.

Register select codes: 0 source address, 1 destination address, 2 count, 3 control, 4 status. Control bits: 0 run, 1 request-paced, 2 interrupt enable, 3 source fixed, 5:4 source size, 6 destination fixed, 8:7 destination size. Status bits: 0 done, 1 bus error, 2 configuration error, 3 busy (read only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| xreq | input | 1 | External transfer request pulse |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 32 | Bus byte address |
| bus_be | output | 4 | Byte lane enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Bus cycle completed |
| bus_err | input | 1 | Bus cycle failed |

## Verification
The completion of the final unit and a software clear of the status word can land on the same clock edge, and the design must let the completion win so the done flag is not lost. The bench provokes this by watching the final write cycle and issuing the status clear so that its write strobe meets the edge at which the bus acknowledges that write; it then reads back done as set and irq as high. A second overlap, an external request arriving while a unit is already on the bus, is provoked in request-paced mode and judged by the count and the number of bus cycles remaining in the reference model.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } state_e;

  typedef struct packed {
    logic [1:0] dsize;
    logic       dfix;
    logic [1:0] ssize;
    logic       sfix;
    logic       irq_en;
    logic       xmode;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // bytes moved by one access of the given size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // distance in bytes of the access from the least significant lane
  function automatic logic [1:0] lane_shift(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      SZ_BYTE: lane_shift = ~a;
      SZ_WORD: lane_shift = {~a[1], 1'b0};
      default: lane_shift = 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_WORD: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] a);
    logic [3:0] base;
    case (sz)
      SZ_BYTE: base = 4'b0001;
      SZ_WORD: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    lane_be = base << lane_shift(sz, a);
  endfunction

  function automatic logic [31:0] lane_extract(input logic [1:0] sz, input logic [1:0] a,
                                               input logic [31:0] d);
    lane_extract = (d >> {lane_shift(sz, a), 3'b000}) & lane_mask(sz);
  endfunction

  function automatic logic [31:0] lane_insert(input logic [1:0] sz, input logic [1:0] a,
                                              input logic [31:0] v);
    lane_insert = (v & lane_mask(sz)) << {lane_shift(sz, a), 3'b000};
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          fixed,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addr <= '0;
    else if (load)            addr <= load_val;
    else if (step && !fixed)  addr <= addr + AW'(size_bytes(size));
  end

  // R4: a fixed side keeps its address across a completed unit
  assert_fixed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fixed && !load) |=> (addr == $past(addr)));

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_chan_pkg::*;
(
  input  logic [1:0] ssize,
  input  logic [1:0] dsize,
  input  logic [1:0] cnt_lo,
  output logic       bad
);

  logic [2:0] sb, db, big, align_mask;

  always_comb begin
    sb         = size_bytes(ssize);
    db         = size_bytes(dsize);
    big        = (sb > db) ? sb : db;
    align_mask = big - 3'd1;
    bad        = (ssize == SZ_LINE) || (dsize == SZ_LINE) ||
                 ((cnt_lo & align_mask[1:0]) != 2'b00);
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          xreq,
  output logic          irq,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err
);

  ctrl_t         ctrl_q, ctrl_in;
  state_e        st_q, st_d;
  logic [CW-1:0] cnt_q, src_step_n;
  logic [31:0]   hold_q;
  logic          done_q, berr_q, cerr_q;
  logic [AW-1:0] src_addr, dst_addr;

  // named events
  logic wr_src, wr_dst, wr_cnt, wr_ctrl, wr_stat;
  logic stop_req, start_req, cfg_bad, clr_stat;
  logic rd_ok, wr_ok, fault, unit_last, set_done, go, busy;

  assign ctrl_in    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign wr_src     = reg_wr && (reg_sel == SEL_SRC);
  assign wr_dst     = reg_wr && (reg_sel == SEL_DST);
  assign wr_cnt     = reg_wr && (reg_sel == SEL_CNT);
  assign wr_ctrl    = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat    = reg_wr && (reg_sel == SEL_STAT);
  assign clr_stat   = wr_stat && reg_wdata[0];
  assign stop_req   = wr_ctrl && !ctrl_in.run;
  assign start_req  = wr_ctrl && ctrl_in.run && (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign src_step_n = CW'(size_bytes(ctrl_q.ssize));
  assign rd_ok      = (st_q == ST_RD) && bus_ack && !bus_err && !stop_req;
  assign wr_ok      = (st_q == ST_WR) && bus_ack && !bus_err && !stop_req;
  assign fault      = bus_req && bus_err && !stop_req;
  assign unit_last  = wr_ok && (cnt_q == src_step_n);
  assign set_done   = unit_last || (start_req && !cfg_bad && (cnt_q == '0));
  assign go         = (st_q == ST_WAIT) && (!ctrl_q.xmode || xreq);

  dma_cfg_check u_cfg (
    .ssize  (ctrl_in.ssize),
    .dsize  (ctrl_in.dsize),
    .cnt_lo (cnt_q[1:0]),
    .bad    (cfg_bad)
  );

  dma_addr_step #(.AW(AW)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_src),
    .load_val (reg_wdata[AW-1:0]),
    .step     (wr_ok),
    .fixed    (ctrl_q.sfix),
    .size     (ctrl_q.ssize),
    .addr     (src_addr)
  );

  dma_addr_step #(.AW(AW)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_dst),
    .load_val (reg_wdata[AW-1:0]),
    .step     (wr_ok),
    .fixed    (ctrl_q.dfix),
    .size     (ctrl_q.dsize),
    .addr     (dst_addr)
  );

  always_comb begin
    st_d = st_q;
    if (stop_req) st_d = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (start_req && !cfg_bad && (cnt_q != '0)) st_d = ST_WAIT;
        ST_WAIT: if (go) st_d = ST_RD;
        ST_RD:   if (fault) st_d = ST_IDLE;
                 else if (rd_ok) st_d = ST_WR;
        ST_WR:   if (fault) st_d = ST_IDLE;
                 else if (wr_ok) st_d = unit_last ? ST_IDLE : ST_WAIT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ctrl_q <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
      berr_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_ctrl) ctrl_q <= ctrl_in;
      if (wr_cnt)      cnt_q <= reg_wdata[CW-1:0];
      else if (wr_ok)  cnt_q <= cnt_q - src_step_n;
      if (rd_ok) hold_q <= lane_extract(ctrl_q.ssize, src_addr[1:0], bus_rdata);
      if (set_done)      done_q <= 1'b1;
      else if (clr_stat) done_q <= 1'b0;
      if (fault)         berr_q <= 1'b1;
      else if (clr_stat) berr_q <= 1'b0;
      if (start_req && cfg_bad) cerr_q <= 1'b1;
      else if (clr_stat)        cerr_q <= 1'b0;
    end
  end

  assign bus_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we    = (st_q == ST_WR);
  assign bus_addr  = bus_we ? dst_addr : src_addr;
  assign bus_be    = bus_we ? lane_be(ctrl_q.dsize, dst_addr[1:0])
                            : lane_be(ctrl_q.ssize, src_addr[1:0]);
  assign bus_wdata = lane_insert(ctrl_q.dsize, dst_addr[1:0], hold_q);
  assign irq       = done_q && ctrl_q.irq_en;

  always_comb begin
    case (reg_sel)
      SEL_SRC:  reg_rdata = 32'(src_addr);
      SEL_DST:  reg_rdata = 32'(dst_addr);
      SEL_CNT:  reg_rdata = 32'(cnt_q);
      SEL_CTRL: reg_rdata = 32'(ctrl_q);
      SEL_STAT: reg_rdata = {28'd0, busy, cerr_q, berr_q, done_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  // R2: an accepted read is followed by the write of the same unit
  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> (bus_req && bus_we));

  // R3: a bad configuration never leaves the idle state
  assert_cfg_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && cfg_bad) |=> (!bus_req && cerr_q));

  // R5: the count falls by the source size per completed unit
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr_cnt) |=> (cnt_q == $past(cnt_q - src_step_n)));

  // R6: lane enables cover one, two or four lanes
  assert_lane_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                 $countones(bus_be) == 4));

  // R8: the last unit leaves the channel idle with done set
  assert_last_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unit_last |=> (done_q && !busy));

  // R9: a run-bit clear drops the bus at once
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !bus_req);

  // R10: an error response halts the channel
  assert_fault_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!bus_req && berr_q && !done_q));

  // R11: completion wins over a same-cycle status clear
  assert_clash_keeps_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_last && clr_stat) |=> done_q);

endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        xreq = 1'b0;
  logic        irq;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 32'd0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int bus_cycles = 0;
  int err_countdown = 0;
  logic [7:0] mem  [0:255];
  logic [7:0] refm [0:255];
  txn_t exp_q[$];

  always #10 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xreq(xreq), .irq(irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err)
  );

  function automatic int nb(input logic [1:0] sz);
    if (sz == 2'b01) return 1;
    if (sz == 2'b10) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] lanes32(input logic [3:0] be);
    logic [31:0] m = 32'd0;
    for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit run, input bit xm, input bit ie,
                                          input bit sf, input logic [1:0] ss,
                                          input bit df, input logic [1:0] ds);
    return {23'd0, ds, df, ss, sf, ie, xm, run};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // behavioural slave: acks one cycle after a request is seen
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; bus_err = 1'b0;
    end else if (bus_ack || bus_err) begin
      bus_ack = 1'b0; bus_err = 1'b0;
    end else if (bus_req) begin
      bus_cycles++;
      if (err_countdown == 1) begin
        err_countdown = 0;
        bus_err = 1'b1;
      end else begin
        if (err_countdown > 1) err_countdown--;
        mon_chk++;
        if (exp_q.size() == 0) begin
          mon_fail++;
          $display("FAIL R2: unexpected bus cycle actual addr %h expected none", bus_addr);
        end else begin
          txn_t e;
          logic [31:0] m;
          e = exp_q.pop_front();
          m = lanes32(e.be);
          if (bus_we !== e.we || bus_addr !== e.addr || bus_be !== e.be ||
              (e.we && ((bus_wdata & m) !== (e.data & m)))) begin
            mon_fail++;
            $display("FAIL R2/R6: bus cycle actual we%0b %h be%b %h expected we%0b %h be%b %h",
                     bus_we, bus_addr, bus_be, bus_wdata, e.we, e.addr, e.be, e.data);
          end
        end
        if (!bus_we) begin
          for (int i = 0; i < 4; i++)
            bus_rdata[31-8*i -: 8] = mem[{bus_addr[7:2], 2'b00} + 8'(i)];
        end else begin
          for (int i = 0; i < 4; i++)
            if (bus_be[3-i]) mem[{bus_addr[7:2], 2'b00} + 8'(i)] = bus_wdata[31-8*i -: 8];
        end
        bus_ack = 1'b1;
      end
    end
  end

  // reference model: expected bus cycles and memory image
  task automatic plan(input logic [31:0] sa0, input logic [31:0] da0, input int cnt,
                      input logic [1:0] ss, input bit sf, input logic [1:0] ds, input bit df);
    logic [31:0] sa = sa0;
    logic [31:0] da = da0;
    int left = cnt;
    while (left > 0) begin
      int sb, db, o;
      logic [31:0] v;
      logic [7:0] b;
      txn_t t;
      sb = nb(ss); db = nb(ds); v = 32'd0;
      for (int i = 0; i < sb; i++) v = (v << 8) | 32'(refm[8'(sa + 32'(i))]);
      t.we = 1'b0; t.addr = sa; t.be = 4'd0; t.data = 32'd0; o = int'(sa[1:0]);
      for (int i = 0; i < sb; i++) t.be[3-(o+i)] = 1'b1;
      exp_q.push_back(t);
      t.we = 1'b1; t.addr = da; t.be = 4'd0; t.data = 32'd0; o = int'(da[1:0]);
      for (int i = 0; i < db; i++) begin
        b = 8'(v >> (8*(db-1-i)));
        refm[8'(da + 32'(i))] = b;
        t.be[3-(o+i)] = 1'b1;
        t.data[31-8*(o+i) -: 8] = b;
      end
      exp_q.push_back(t);
      if (!sf) sa = sa + 32'(sb);
      if (!df) da = da + 32'(db);
      left -= sb;
    end
  endtask

  task automatic flush();
    exp_q.delete();
    for (int i = 0; i < 256; i++) refm[i] = mem[i];
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd_reg(3'd4, v);
      if (!v[3]) break;
    end
  endtask

  task automatic setup(input logic [31:0] sa, input logic [31:0] da, input logic [31:0] cnt);
    wr_reg(3'd0, sa);
    wr_reg(3'd1, da);
    wr_reg(3'd2, cnt);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk + 1, n_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bc;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 37 + 11);
      refm[i] = 8'(i * 37 + 11);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd4, v); chk(v == 32'd0, "R1 status after reset", v, 0);
    rd_reg(3'd2, v); chk(v == 32'd0, "R1 count after reset", v, 0);
    chk(!bus_req && !irq, "R1 bus_req/irq after reset", {bus_req, irq}, 0);

    // long to long, both stepping, interrupt enabled
    plan(32'h00, 32'h80, 8, 2'b00, 0, 2'b00, 0);
    setup(32'h00, 32'h80, 8);
    wr_reg(3'd3, mk_ctrl(1, 0, 1, 0, 2'b00, 0, 2'b00));
    wait_idle();
    rd_reg(3'd4, v); chk(v == 32'd1, "R8 done after long copy", v, 1);
    chk(irq == 1'b1, "R8 irq with enable", irq, 1);
    rd_reg(3'd2, v); chk(v == 32'd0, "R5 count zero at end", v, 0);
    rd_reg(3'd0, v); chk(v == 32'h08, "R4 src stepped by 4", v, 32'h08);
    rd_reg(3'd1, v); chk(v == 32'h88, "R4 dst stepped by 4", v, 32'h88);
    chk(exp_q.size() == 0, "R2 all cycles seen", exp_q.size(), 0);
    wr_reg(3'd4, 32'd1);
    rd_reg(3'd4, v); chk(v == 32'd0, "R11 status cleared", v, 0);
    chk(irq == 1'b0, "R8 irq follows done", irq, 0);

    // byte source at odd offset into word destination
    plan(32'h21, 32'h90, 4, 2'b01, 0, 2'b10, 0);
    setup(32'h21, 32'h90, 4);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 0, 2'b01, 0, 2'b10));
    wait_idle();
    rd_reg(3'd0, v); chk(v == 32'h25, "R4 byte source step", v, 32'h25);
    rd_reg(3'd1, v); chk(v == 32'h98, "R4 word destination step", v, 32'h98);
    chk(irq == 1'b0, "R8 irq masked when disabled", irq, 0);
    for (int i = 8'h90; i < 8'h98; i++)
      chk(mem[i] == refm[i], "R6 zero-extended word data", mem[i], refm[i]);
    wr_reg(3'd4, 32'd1);

    // fixed word source into stepping byte destination
    plan(32'h52, 32'hA0, 4, 2'b10, 1, 2'b01, 0);
    setup(32'h52, 32'hA0, 4);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 1, 2'b10, 0, 2'b01));
    wait_idle();
    rd_reg(3'd0, v); chk(v == 32'h52, "R4 fixed source holds", v, 32'h52);
    rd_reg(3'd1, v); chk(v == 32'hA2, "R4 byte destination step", v, 32'hA2);
    chk(mem[8'hA0] == refm[8'hA0] && mem[8'hA1] == refm[8'hA1],
        "R6 low byte of word", {mem[8'hA0], mem[8'hA1]}, {refm[8'hA0], refm[8'hA1]});
    wr_reg(3'd4, 32'd1);

    // configuration errors
    bc = bus_cycles;
    setup(32'h00, 32'hF0, 8);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 0, 2'b11, 0, 2'b00));
    repeat (5) @(negedge clk);
    rd_reg(3'd4, v); chk(v == 32'd4, "R3 reserved size flags error", v, 4);
    wr_reg(3'd4, 32'd1);
    rd_reg(3'd4, v); chk(v == 32'd0, "R11 clear config error", v, 0);
    wr_reg(3'd2, 32'd6);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 0, 2'b00, 0, 2'b01));
    repeat (5) @(negedge clk);
    rd_reg(3'd4, v); chk(v == 32'd4, "R3 misaligned count flags error", v, 4);
    chk(bus_cycles == bc, "R3 no bus cycle on bad config", bus_cycles, bc);
    wr_reg(3'd4, 32'd1);

    // count width
    wr_reg(3'd2, 32'hAB00_0010);
    rd_reg(3'd2, v); chk(v == 32'h10, "R5 upper count bits dropped", v, 32'h10);

    // zero count
    bc = bus_cycles;
    wr_reg(3'd2, 32'd0);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 0, 2'b00, 0, 2'b00));
    repeat (3) @(negedge clk);
    rd_reg(3'd4, v); chk(v == 32'd1, "R12 zero count done at once", v, 1);
    chk(bus_cycles == bc, "R12 no bus cycle", bus_cycles, bc);
    wr_reg(3'd4, 32'd1);

    // request-paced mode
    plan(32'h30, 32'hB0, 8, 2'b01, 0, 2'b01, 0);
    setup(32'h30, 32'hB0, 8);
    wr_reg(3'd3, mk_ctrl(1, 1, 0, 0, 2'b01, 0, 2'b01));
    repeat (10) @(negedge clk);
    rd_reg(3'd2, v); chk(v == 32'd8, "R7 no unit without request", v, 8);
    @(negedge clk); xreq = 1'b1;
    @(negedge clk); xreq = 1'b0;
    @(negedge clk); xreq = 1'b1;
    @(negedge clk); xreq = 1'b0;
    repeat (20) @(negedge clk);
    rd_reg(3'd2, v); chk(v == 32'd7, "R7 one unit per pulse, busy pulse ignored", v, 7);
    chk(exp_q.size() == 14, "R7 two bus cycles per unit", exp_q.size(), 14);
    @(negedge clk); xreq = 1'b1;
    @(negedge clk); xreq = 1'b0;
    repeat (20) @(negedge clk);
    rd_reg(3'd2, v); chk(v == 32'd6, "R7 second accepted pulse", v, 6);
    wr_reg(3'd3, mk_ctrl(0, 1, 0, 0, 2'b01, 0, 2'b01));
    flush();

    // abort by run-bit clear
    plan(32'h00, 32'hC0, 32, 2'b00, 0, 2'b00, 0);
    setup(32'h00, 32'hC0, 32);
    wr_reg(3'd3, mk_ctrl(1, 0, 0, 0, 2'b00, 0, 2'b00));
    repeat (5) @(negedge clk);
    wr_reg(3'd3, mk_ctrl(0, 0, 0, 0, 2'b00, 0, 2'b00));
    chk(bus_req == 1'b0, "R9 bus released after stop", bus_req, 0);
    bc = bus_cycles;
    repeat (20) @(negedge clk);
    chk(bus_cycles == bc, "R9 no cycle after stop", bus_cycles, bc);
    rd_reg(3'd4, v); chk(v == 32'd0, "R9 no done after stop", v, 0);
    flush();

    // bus error on the first write
    plan(32'h08, 32'hD0, 8, 2'b00, 0, 2'b00, 0);
    setup(32'h08, 32'hD0, 8);
    err_countdown = 2;
    wr_reg(3'd3, mk_ctrl(1, 0, 1, 0, 2'b00, 0, 2'b00));
    wait_idle();
    rd_reg(3'd4, v); chk(v == 32'd2, "R10 error bit, no done", v, 2);
    rd_reg(3'd2, v); chk(v == 32'd8, "R10 count kept", v, 8);
    chk(irq == 1'b0, "R10 no irq on error", irq, 0);
    flush();
    wr_reg(3'd4, 32'd1);
    rd_reg(3'd4, v); chk(v == 32'd0, "R11 clear bus error", v, 0);

    // completion and status clear on the same edge
    plan(32'h10, 32'hE0, 4, 2'b00, 0, 2'b00, 0);
    setup(32'h10, 32'hE0, 4);
    wr_reg(3'd3, mk_ctrl(1, 0, 1, 0, 2'b00, 0, 2'b00));
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); #1;
      if (bus_req && bus_we && !bus_ack) break;
    end
    reg_sel = 3'd4; reg_wdata = 32'd1; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    @(negedge clk);
    rd_reg(3'd4, v); chk(v == 32'd1, "R11 done survives same-cycle clear", v, 1);
    chk(irq == 1'b1, "R8 irq after clash", irq, 1);
    chk(exp_q.size() == 0, "R2 clash transfer complete", exp_q.size(), 0);
    wr_reg(3'd4, 32'd1);
    rd_reg(3'd4, v); chk(v == 32'd0, "R11 later clear works", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

endmodule